// File: doc/BRIEF.md
# Multi-Port RAM with Per-Port Write Bypass

This block is a word-addressed storage array with a configurable number of write ports and read ports, all on one clock. Each write port carries an address, a data word and a vector of lane enables. Each enable bit covers one contiguous slice of the word, so a write can update part of a word and leave the rest as it was. A read port is either combinational or registered. A combinational port follows the addressed word at all times. A registered port captures a new value only on an edge where its read enable is set.

Each registered read port has its own list of write ports whose same-edge writes bypass into it. When a listed port writes the address being read, the enabled lanes of that write appear in the captured word, and the other lanes come from storage. Writes from ports that are not listed are not seen until the next read.

The contents load from a parameter image at reset. A global gate input, which a parameter can enable, suspends all writes and all registered-read captures while it is low. Accesses at addresses outside the array are defined: a read returns zero and a write changes nothing.

Top module: `mprRam`

## Requirements
- R1: The address width is ceil(log2(DEPTH)). A write port has LANES enable bits. Lane width is WIDTH/LANES, and enable bit j controls data bits [j*WIDTH/LANES +: WIDTH/LANES]. If WIDTH is not a multiple of LANES, elaboration fails.
- R2: On a rising clock edge a write port updates its addressed word lane by lane: new = (wrData AND mask) OR (old AND NOT mask), where mask is each lane bit repeated across its lane.
- R3: A read port whose RD_SYNC bit is 0 is combinational. Its rdData shows the addressed word continuously, including a word written on the latest edge, and its rdEn is ignored.
- R4: A read port whose RD_SYNC bit is 1 loads its output register on an edge where rdEn is 1, and holds its previous value otherwise.
- R5: Bit r*NUM_WR+w of TRANSP makes write port w transparent to registered read port r. On a same-edge write to the read address, the lanes enabled by a listed port are taken from its write data. An unlisted port's write is not seen, and the old stored value is returned.
- R6: A read at an address >= DEPTH returns 0. A write to such an address, or a write with an all-zero lane vector, changes no word.
- R7: While rstN is low, word i is INIT[i*WIDTH +: WIDTH] for i < INIT_LEN and 0 otherwise, and registered read outputs are 0. If INIT_LEN > DEPTH, elaboration fails.
- R8: With GATE_USED=1 and gateEn=0, no write takes effect and no registered read port loads. With GATE_USED=0, gateEn has no effect.
- R9: When several write ports hit the same address on one edge, they apply in ascending port index, so the highest index wins on lanes that overlap and each port's other lanes still land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all writes and registered reads |
| rstN | input | 1 | Asynchronous active-low reset; reloads the image |
| gateEn | input | 1 | Global clock-enable gate for writes and registered reads |
| wrAddr | input | NUM_WR*AW | Write address for each write port |
| wrData | input | NUM_WR*WIDTH | Write data for each write port |
| wrLane | input | NUM_WR*LANES | Lane enables for each write port |
| rdAddr | input | NUM_RD*AW | Read address for each read port |
| rdEn | input | NUM_RD | Read enable for each read port (used by registered ports only) |
| rdData | output | NUM_RD*WIDTH | Read data for each read port |

## Verification
Bad storage stays hidden until a port reads that word. The combinational port exposes it one edge after the faulty write, so the bench reads back every word it writes through that port on the same edge. A wrong bypass or priority decision shows on the registered ports on the very edge of the write. For that reason the bench includes an edge where two write ports collide on one address while two readers with different bypass lists read it. If the gate or the range check leaks, the damage only appears on a later read of the protected word, so those cases are followed by explicit read-backs.

// File: rtl/mprPkg.sv
package mprPkg;

  // Kind of a read port as selected by one RD_SYNC bit (R3, R4)
  typedef enum logic {
    RD_COMB = 1'b0,
    RD_REG  = 1'b1
  } rdKind_e;

  // Position of the (read port, write port) pair inside the TRANSP vector (R5)
  function automatic int pairIdx(input int rd, input int wr, input int nWr);
    return rd * nWr + wr;
  endfunction

endpackage

// File: rtl/mprCtrl.sv
module mprCtrl import mprPkg::*; #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 12,
  parameter int LANES = 2,
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 3,
  parameter int AW = 4,
  parameter logic [NUM_RD-1:0] RD_SYNC = '1,
  parameter bit GATE_USED = 1'b1,
  parameter type strobe_t = logic
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateEn,
  input  logic [NUM_WR-1:0][AW-1:0] wrAddr,
  input  logic [NUM_WR-1:0][LANES-1:0] wrLane,
  input  logic [NUM_RD-1:0][AW-1:0] rdAddr,
  input  logic [NUM_RD-1:0] rdEn,
  output strobe_t strb
);

  localparam int LW = WIDTH / LANES;

  logic gateOk;

  generate
    if (GATE_USED) begin : g_gate
      assign gateOk = gateEn;
    end else begin : g_noGate
      assign gateOk = 1'b1;
    end
  endgenerate

  always_comb begin
    strb = '0;
    for (int w = 0; w < NUM_WR; w++) begin
      if (int'(wrAddr[w]) < DEPTH) begin
        for (int l = 0; l < LANES; l++) begin
          strb.wrMask[w][l*LW +: LW] = {LW{wrLane[w][l] & gateOk}};
        end
      end
    end
    for (int r = 0; r < NUM_RD; r++) begin
      strb.rdInRange[r] = int'(rdAddr[r]) < DEPTH;
      strb.rdLoad[r]    = rdEn[r] & gateOk & (rdKind_e'(RD_SYNC[r]) == RD_REG);
    end
  end

  // R8
  gate_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (GATE_USED && !gateEn) |-> (strb.wrMask == '0 && strb.rdLoad == '0));

  generate
    for (genvar w = 0; w < NUM_WR; w++) begin : g_wrChk
      // R6
      wr_oor_chk: assert property (@(posedge clk) disable iff (!rstN)
        (int'(wrAddr[w]) >= DEPTH) |-> (strb.wrMask[w] == '0));
    end
  endgenerate

endmodule

// File: rtl/mprData.sv
module mprData import mprPkg::*; #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 12,
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 3,
  parameter int AW = 4,
  parameter logic [NUM_RD-1:0] RD_SYNC = '1,
  parameter logic [NUM_RD*NUM_WR-1:0] TRANSP = '0,
  parameter int INIT_LEN = 0,
  parameter logic [DEPTH*WIDTH-1:0] INIT = '0,
  parameter type strobe_t = logic
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_WR-1:0][AW-1:0] wrAddr,
  input  logic [NUM_WR-1:0][WIDTH-1:0] wrData,
  input  logic [NUM_RD-1:0][AW-1:0] rdAddr,
  input  strobe_t strb,
  output logic [NUM_RD-1:0][WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] mem     [DEPTH];
  logic [WIDTH-1:0] memNext [DEPTH];
  logic [NUM_RD-1:0][WIDTH-1:0] rawRd;

  // Every write of this edge merges into one next image, lowest port first
  always_comb begin
    memNext = mem;
    for (int w = 0; w < NUM_WR; w++) begin
      if (int'(wrAddr[w]) < DEPTH && (|strb.wrMask[w])) begin
        memNext[wrAddr[w]] = (wrData[w] & strb.wrMask[w]) |
                             (memNext[wrAddr[w]] & ~strb.wrMask[w]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= (i < INIT_LEN) ? INIT[i*WIDTH +: WIDTH] : '0;
      end
    end else begin
      mem <= memNext;
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_RD; r++) begin
      rawRd[r] = strb.rdInRange[r] ? mem[rdAddr[r]] : '0;
    end
  end

  generate
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      if (rdKind_e'(RD_SYNC[r]) == RD_REG) begin : g_reg
        logic [WIDTH-1:0] fwd;
        logic [WIDTH-1:0] rdReg;

        always_comb begin
          fwd = rawRd[r];
          for (int w = 0; w < NUM_WR; w++) begin
            if (TRANSP[pairIdx(r, w, NUM_WR)] && strb.rdInRange[r] &&
                rdAddr[r] == wrAddr[w]) begin
              fwd = (wrData[w] & strb.wrMask[w]) | (fwd & ~strb.wrMask[w]);
            end
          end
        end

        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            rdReg <= '0;
          end else if (strb.rdLoad[r]) begin
            rdReg <= fwd;
          end
        end

        assign rdData[r] = rdReg;

        // R4
        rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
          !strb.rdLoad[r] |=> $stable(rdData[r]));

        // R6
        rd_oor_chk: assert property (@(posedge clk) disable iff (!rstN)
          (strb.rdLoad[r] && int'(rdAddr[r]) >= DEPTH) |=> (rdData[r] == '0));
      end else begin : g_comb
        assign rdData[r] = rawRd[r];
      end
    end
  endgenerate

endmodule

// File: rtl/mprRam.sv
module mprRam import mprPkg::*; #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 12,
  parameter int LANES = 2,
  parameter int NUM_WR = 2,
  parameter int NUM_RD = 3,
  parameter logic [NUM_RD-1:0] RD_SYNC = 3'b110,
  parameter logic [NUM_RD*NUM_WR-1:0] TRANSP = 6'b110100,
  parameter int INIT_LEN = 4,
  parameter logic [DEPTH*WIDTH-1:0] INIT = (DEPTH*WIDTH)'(64'h1A1A_2B2B_3C3C_4D4D),
  parameter bit GATE_USED = 1'b1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic gateEn,
  input  logic [NUM_WR-1:0][AW-1:0] wrAddr,
  input  logic [NUM_WR-1:0][WIDTH-1:0] wrData,
  input  logic [NUM_WR-1:0][LANES-1:0] wrLane,
  input  logic [NUM_RD-1:0][AW-1:0] rdAddr,
  input  logic [NUM_RD-1:0] rdEn,
  output logic [NUM_RD-1:0][WIDTH-1:0] rdData
);

  // Strobes from the control to the datapath
  typedef struct packed {
    logic [NUM_WR-1:0][WIDTH-1:0] wrMask;
    logic [NUM_RD-1:0] rdLoad;
    logic [NUM_RD-1:0] rdInRange;
  } strobe_t;

  strobe_t strb;

  // R1, R7: configuration checks
  generate
    if (WIDTH % LANES != 0) begin : g_badLanes
      $error("lane count must divide the word width");
    end
    if (INIT_LEN > DEPTH) begin : g_badInit
      $error("init image longer than the array");
    end
  endgenerate

  mprCtrl #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .LANES(LANES), .NUM_WR(NUM_WR), .NUM_RD(NUM_RD),
    .AW(AW), .RD_SYNC(RD_SYNC), .GATE_USED(GATE_USED), .strobe_t(strobe_t)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .gateEn(gateEn), .wrAddr(wrAddr), .wrLane(wrLane),
    .rdAddr(rdAddr), .rdEn(rdEn), .strb(strb)
  );

  mprData #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .NUM_WR(NUM_WR), .NUM_RD(NUM_RD), .AW(AW),
    .RD_SYNC(RD_SYNC), .TRANSP(TRANSP), .INIT_LEN(INIT_LEN), .INIT(INIT),
    .strobe_t(strobe_t)
  ) uData (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .strb(strb), .rdData(rdData)
  );

endmodule

// File: tb/tb_mprRam.sv
`timescale 1ns/1ps
module tb_mprRam;
  localparam int W = 16, D = 12, NW = 2, NR = 3, AW = 4, LN = 2, LW = 8;
  localparam bit [NR-1:0] SYNCM = 3'b110;
  localparam bit [NR*NW-1:0] TR = 6'b110100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, gateEn;
  logic [NW-1:0][AW-1:0] wrAddr;
  logic [NW-1:0][W-1:0] wrData;
  logic [NW-1:0][LN-1:0] wrLane;
  logic [NR-1:0][AW-1:0] rdAddr;
  logic [NR-1:0] rdEn;
  logic [NR-1:0][W-1:0] rdData;

  mprRam dut (.clk(clk), .rstN(rstN), .gateEn(gateEn), .wrAddr(wrAddr), .wrData(wrData),
              .wrLane(wrLane), .rdAddr(rdAddr), .rdEn(rdEn), .rdData(rdData));

  typedef struct {
    int port;
    logic [W-1:0] exp;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] mdl [D];
  logic [W-1:0] expReg [NR];

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    gateEn = 1'b1;
    wrLane = '0; wrAddr = '0; wrData = '0;
    rdEn = '0;
  endtask

  // Driver: computes the expected port values after the coming edge and queues them
  task automatic step(input string tag);
    logic [W-1:0] m [NW];
    logic [W-1:0] v;
    item_t it;
    for (int w = 0; w < NW; w++) begin
      m[w] = '0;
      if (int'(wrAddr[w]) < D && gateEn)
        for (int l = 0; l < LN; l++) if (wrLane[w][l]) m[w][l*LW +: LW] = '1;
    end
    for (int r = 0; r < NR; r++) begin
      if (SYNCM[r] && rdEn[r] && gateEn) begin
        v = (int'(rdAddr[r]) < D) ? mdl[rdAddr[r]] : '0;
        for (int w = 0; w < NW; w++)
          if (TR[r*NW+w] && int'(rdAddr[r]) < D && rdAddr[r] == wrAddr[w])
            v = (wrData[w] & m[w]) | (v & ~m[w]);
        expReg[r] = v;
      end
    end
    for (int w = 0; w < NW; w++)
      if (int'(wrAddr[w]) < D)
        mdl[wrAddr[w]] = (wrData[w] & m[w]) | (mdl[wrAddr[w]] & ~m[w]);
    for (int r = 0; r < NR; r++) begin
      it.port = r;
      it.tag = $sformatf("%s port%0d", tag, r);
      if (SYNCM[r]) it.exp = expReg[r];
      else it.exp = (int'(rdAddr[r]) < D) ? mdl[rdAddr[r]] : '0;
      q.push_back(it);
    end
    @(posedge clk);
  endtask

  // Monitor: compares queued expectations one ns after the edge
  always @(posedge clk) begin
    item_t it;
    #1;
    while (q.size() > 0) begin
      it = q.pop_front();
      chk(it.tag, rdData[it.port], it.exp);
    end
  end

  initial begin
    rstN = 1'b0;
    idle();
    rdAddr = '0;
    rdAddr[0] = 4'd1;
    #12;
    chk("R7 init word1", rdData[0], 16'h3C3C);
    chk("R7 reg port1 reset", rdData[1], 16'h0000);
    chk("R7 reg port2 reset", rdData[2], 16'h0000);
    rdAddr[0] = 4'd5;
    #1;
    chk("R7 zero fill word5", rdData[0], 16'h0000);
    for (int i = 0; i < D; i++) mdl[i] = '0;
    mdl[0] = 16'h4D4D; mdl[1] = 16'h3C3C; mdl[2] = 16'h2B2B; mdl[3] = 16'h1A1A;
    for (int r = 0; r < NR; r++) expReg[r] = '0;
    @(negedge clk);
    rstN = 1'b1;

    // full word write, both registered readers bypass port0
    @(negedge clk); idle();
    wrAddr[0] = 4'd5; wrData[0] = 16'h1234; wrLane[0] = 2'b11;
    rdAddr = {4'd5, 4'd5, 4'd5}; rdEn = 3'b110;
    step("R2 R5 bypass full word");

    // low-lane write by port1: port1 reader not listed, port2 reader listed
    @(negedge clk); idle();
    wrAddr[1] = 4'd5; wrData[1] = 16'hABCD; wrLane[1] = 2'b01;
    rdAddr = {4'd5, 4'd5, 4'd5}; rdEn = 3'b110;
    step("R1 R5 lane write unlisted vs listed");

    @(negedge clk); idle();
    rdAddr = {4'd5, 4'd5, 4'd0}; rdEn = 3'b110;
    step("R2 R4 merged word readback");

    // enables low: registered ports hold, combinational follows anyway
    @(negedge clk); idle();
    rdAddr = {4'd0, 4'd0, 4'd0}; rdEn = 3'b000;
    step("R3 R4 hold and follow");

    // both write ports hit word7 on one edge
    @(negedge clk); idle();
    wrAddr[0] = 4'd7; wrData[0] = 16'h1111; wrLane[0] = 2'b11;
    wrAddr[1] = 4'd7; wrData[1] = 16'h2222; wrLane[1] = 2'b10;
    rdAddr = {4'd7, 4'd7, 4'd7}; rdEn = 3'b110;
    step("R9 R5 collision");

    // out of range write and read, zero-lane write
    @(negedge clk); idle();
    wrAddr[0] = 4'd13; wrData[0] = 16'hFFFF; wrLane[0] = 2'b11;
    wrAddr[1] = 4'd2; wrData[1] = 16'h5555; wrLane[1] = 2'b00;
    rdAddr = {4'd2, 4'd13, 4'd13}; rdEn = 3'b110;
    step("R6 out of range and zero lanes");

    @(negedge clk); idle();
    rdAddr = {4'd5, 4'd2, 4'd1}; rdEn = 3'b110;
    step("R6 words untouched");

    // gate low blocks write and captures
    @(negedge clk); idle();
    gateEn = 1'b0;
    wrAddr[0] = 4'd3; wrData[0] = 16'h9999; wrLane[0] = 2'b11;
    rdAddr = {4'd3, 4'd3, 4'd3}; rdEn = 3'b110;
    step("R8 gate low");

    @(negedge clk); idle();
    rdAddr = {4'd3, 4'd3, 4'd7}; rdEn = 3'b110;
    step("R8 gate high readback");

    @(negedge clk); idle();
    @(posedge clk); #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule